// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a bank of ordinary peripheral interrupt requests together with a few non-maskable trap requests. It reduces them to one request line toward a processor. For the source that wins, it presents a vector number and the program-memory address of that source's entry in a vector table.

Arbitration works on two levels. Each ordinary source carries a programmable level from 0 to 7, and the highest level wins. Among sources at equal level, the lower vector number wins. Traps sit above every ordinary source and ignore enables. A single table-select input redirects every lookup to an alternate table. That table has the same layout and starts right after the primary one.

The block also tracks the processor's running priority. Accepting a request raises that priority to the winner's level and saves the old value on a small stack. A return from the handler restores the saved value. The result appears a fixed two clock edges after the inputs that cause it.

Top module: `prio_vector_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `int_req` is 0, `vec_num` is 0, `vec_addr` is 0, `req_level` is 0 and `cpu_level` is 0, whatever the request inputs are.
- R2: Trap `t` has vector number `t` and reports level 8. A pending trap beats every ordinary source, needs no enable, and is forwarded only while `cpu_level` is below 8.
- R3: Ordinary source `i` takes part in arbitration only when its flag is 1, its enable is 1, and its 3-bit level (bits `3*i+2 .. 3*i` of `irq_prio`) is strictly greater than `cpu_level`. A level of 0 therefore never requests.
- R4: The qualified candidate with the highest level wins. Among equal levels the lowest vector number wins. Ordinary source `i` has vector number `NUM_TRAPS+i`, and `req_level` shows the winner's level.
- R5: `vec_addr` is 0x000004 + 2*`vec_num` when `alt_sel` is 0. When `alt_sel` is 1 it is 0x000004 + 2*(`NUM_TRAPS`+`NUM_IRQ`) + 2*`vec_num`.
- R6: Inputs held stable ahead of clock edge k are reflected on `int_req`, `vec_num`, `vec_addr` and `req_level` after edge k+1, not after edge k. While nothing qualifies, these outputs read 0.
- R7: `cpu_ack` while `int_req` is 1 sets `cpu_level` to `req_level` at that edge and saves the previous level. `int_req` then reads 0 after that edge and the next one.
- R8: `cpu_ret` restores the most recently saved level. It is ignored when nothing is saved, and also when it coincides with an accepted `cpu_ack`.
- R9: `cpu_ack` while `int_req` is 0 changes neither `cpu_level` nor the saved levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | NUM_TRAPS | Pending trap requests, bit t is vector t |
| irq_flag | input | NUM_IRQ | Pending ordinary request flags |
| irq_en | input | NUM_IRQ | Per-source enables |
| irq_prio | input | 3*NUM_IRQ | Per-source levels, 3 bits each |
| alt_sel | input | 1 | 1 selects the alternate vector table |
| cpu_ack | input | 1 | Processor accepts the presented request |
| cpu_ret | input | 1 | Processor returns from a handler |
| int_req | output | 1 | Request toward the processor |
| vec_num | output | clog2(NUM_TRAPS+NUM_IRQ) | Winning vector number |
| vec_addr | output | 24 | Program address of the winning vector entry |
| req_level | output | 4 | Level of the presented request (8 for traps) |
| cpu_level | output | 4 | Current processor priority |

## Verification
The bench builds the block with 4 traps and 12 ordinary sources. That makes a 16-entry table, so the alternate table starts at 0x24 and address arithmetic is easy to check by hand. With so few sources, every tie between equal levels and every trap-over-source case fits in a short table of vectors. Nesting reaches level 8 through a chain of three acceptances, which exercises the saved-level stack in both directions.

// File: rtl/pvc_pkg.sv
`timescale 1ns/1ps
package pvc_pkg;
  localparam int ADDR_W = 24;
  localparam int LVL_W = 4;
  localparam int PRIO_W = 3;
  localparam logic [LVL_W-1:0] TRAP_LVL = 4'd8;
  localparam int PRI_BASE = 4;

  // start of the alternate table: right after the primary one
  function automatic int alt_base_f(input int total);
    return PRI_BASE + 2 * total;
  endfunction

  // program address of one vector entry, two address units per entry
  function automatic logic [ADDR_W-1:0] vec_addr_f(input logic alt, input int vec, input int total);
    int base;
    base = alt ? alt_base_f(total) : PRI_BASE;
    return ADDR_W'(base + 2 * vec);
  endfunction
endpackage

// File: rtl/pvc_qualify.sv
`timescale 1ns/1ps
module pvc_qualify
  import pvc_pkg::*;
#(
  parameter int NUM_TRAPS = 8,
  parameter int NUM_IRQ = 118,
  localparam int TOTAL = NUM_TRAPS + NUM_IRQ
) (
  input  logic [NUM_TRAPS-1:0]          trap_req,
  input  logic [NUM_IRQ-1:0]            irq_flag,
  input  logic [NUM_IRQ-1:0]            irq_en,
  input  logic [PRIO_W*NUM_IRQ-1:0]     irq_prio,
  input  logic [LVL_W-1:0]              cpu_level,
  output logic [TOTAL-1:0][LVL_W-1:0]   cand_lvl
);
  // traps: fixed top level, no enable, blocked only inside a trap handler
  for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
    assign cand_lvl[t] = (trap_req[t] && (cpu_level < TRAP_LVL)) ? TRAP_LVL : '0;
  end

  // ordinary sources: flag, enable and strictly above the running level
  for (genvar s = 0; s < NUM_IRQ; s++) begin : g_src
    logic [LVL_W-1:0] own_lvl;
    logic             live;
    assign own_lvl = LVL_W'(irq_prio[s*PRIO_W +: PRIO_W]);
    assign live    = irq_flag[s] && irq_en[s] && (own_lvl > cpu_level);
    assign cand_lvl[NUM_TRAPS+s] = live ? own_lvl : '0;
  end
endmodule

// File: rtl/pvc_arbiter.sv
`timescale 1ns/1ps
module pvc_arbiter
  import pvc_pkg::*;
#(
  parameter int TOTAL = 126,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic [TOTAL-1:0][LVL_W-1:0] cand_lvl,
  output logic                        win_valid,
  output logic [IDX_W-1:0]            win_idx,
  output logic [LVL_W-1:0]            win_lvl
);
  // scan from the highest vector down; ">=" lets lower numbers take ties
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = TOTAL - 1; i >= 0; i--) begin
      if ((cand_lvl[i] != '0) && (cand_lvl[i] >= win_lvl)) begin
        win_lvl = cand_lvl[i];
        win_idx = IDX_W'(i);
      end
    end
    win_valid = (win_lvl != '0);
  end
endmodule

// File: rtl/pvc_level_stack.sv
`timescale 1ns/1ps
module pvc_level_stack
  import pvc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] push_lvl,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [CNT_W-1:0] depth
);
  logic [DEPTH-1:0][LVL_W-1:0] saved;
  logic [LVL_W-1:0]            top_lvl;
  logic                        pop_ok;

  assign pop_ok = pop && !push && (depth != '0);

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i + 1 == int'(depth)) top_lvl = saved[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved   <= '0;
      cur_lvl <= '0;
      depth   <= '0;
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(depth)) saved[i] <= cur_lvl;
      end
      cur_lvl <= push_lvl;
      depth   <= depth + 1'b1;
    end else if (pop_ok) begin
      cur_lvl <= top_lvl;
      depth   <= depth - 1'b1;
    end
  end

  // R7: levels only rise on acceptance, so the stack never overfills
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(depth) < DEPTH));

  // R8: a valid return removes exactly one saved level
  assert_pop_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (depth == $past(depth) - 1'b1));

  // R8: a return with nothing saved leaves the level alone
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth == '0) |=> $stable(cur_lvl));
endmodule

// File: rtl/prio_vector_ctrl.sv
`timescale 1ns/1ps
module prio_vector_ctrl
  import pvc_pkg::*;
#(
  parameter int NUM_TRAPS = 8,
  parameter int NUM_IRQ = 118,
  localparam int TOTAL = NUM_TRAPS + NUM_IRQ,
  localparam int VEC_W = $clog2(TOTAL)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_TRAPS-1:0]      trap_req,
  input  logic [NUM_IRQ-1:0]        irq_flag,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [PRIO_W*NUM_IRQ-1:0] irq_prio,
  input  logic                      alt_sel,
  input  logic                      cpu_ack,
  input  logic                      cpu_ret,
  output logic                      int_req,
  output logic [VEC_W-1:0]          vec_num,
  output logic [ADDR_W-1:0]         vec_addr,
  output logic [LVL_W-1:0]          req_level,
  output logic [LVL_W-1:0]          cpu_level
);
  localparam int STACK_DEPTH = int'(TRAP_LVL);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  logic [TOTAL-1:0][LVL_W-1:0] cand_lvl;
  logic                        win_valid;
  logic [VEC_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic                        accept;
  logic                        ret_req;
  logic [CNT_W-1:0]            stk_depth;

  // stage 1 registers
  logic             s1_valid;
  logic [VEC_W-1:0] s1_vec;
  logic [LVL_W-1:0] s1_lvl;
  logic             s1_alt;

  assign accept  = cpu_ack && int_req;
  assign ret_req = cpu_ret && !accept;

  pvc_qualify #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQ(NUM_IRQ)) u_qualify (
    .trap_req (trap_req),
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .irq_prio (irq_prio),
    .cpu_level(cpu_level),
    .cand_lvl (cand_lvl)
  );

  pvc_arbiter #(.TOTAL(TOTAL)) u_arbiter (
    .cand_lvl (cand_lvl),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  pvc_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept),
    .pop     (ret_req),
    .push_lvl(req_level),
    .cur_lvl (cpu_level),
    .depth   (stk_depth)
  );

  // two-stage pipeline: arbitration result, then vector lookup.
  // an acceptance flushes both stages, since held results used the old level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_vec    <= '0;
      s1_lvl    <= '0;
      s1_alt    <= 1'b0;
      int_req   <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
      req_level <= '0;
    end else if (accept) begin
      s1_valid  <= 1'b0;
      s1_vec    <= '0;
      s1_lvl    <= '0;
      s1_alt    <= 1'b0;
      int_req   <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
      req_level <= '0;
    end else begin
      s1_valid  <= win_valid;
      s1_vec    <= win_valid ? win_idx : '0;
      s1_lvl    <= win_lvl;
      s1_alt    <= alt_sel;
      int_req   <= s1_valid;
      vec_num   <= s1_vec;
      vec_addr  <= s1_valid ? vec_addr_f(s1_alt, int'(s1_vec), TOTAL) : '0;
      req_level <= s1_lvl;
    end
  end

  // R2: any forwardable trap wins arbitration over ordinary sources
  assert_trap_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trap_req) && (cpu_level < TRAP_LVL)) |-> (int'(win_idx) < NUM_TRAPS));

  // R3: a presented request always outranks the running level
  assert_above_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (req_level > cpu_level));

  // R5: the presented address lies inside one of the two tables
  assert_addr_in_table_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((int'(vec_addr) >= PRI_BASE) && (int'(vec_addr) < alt_base_f(TOTAL) + 2 * TOTAL)));

  // R7: acceptance raises the running level to the presented one
  assert_ack_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cpu_level == $past(req_level)));

  // R7: acceptance withdraws the request on the following cycle
  assert_ack_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !int_req);

  // R9: an acknowledge without a request leaves the level unchanged
  assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !int_req && !cpu_ret) |=> $stable(cpu_level));
endmodule

// File: tb/prio_vector_ctrl_tb.sv
`timescale 1ns/1ps
module prio_vector_ctrl_tb;
  localparam int NT = 4;
  localparam int NI = 12;
  localparam int TOT = NT + NI;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trap_req = '0;
  logic [NI-1:0] irq_flag = '0;
  logic [NI-1:0] irq_en = '0;
  logic [3*NI-1:0] irq_prio = '0;
  logic          alt_sel = 1'b0;
  logic          cpu_ack = 1'b0;
  logic          cpu_ret = 1'b0;
  logic          int_req;
  logic [3:0]    vec_num;
  logic [23:0]   vec_addr;
  logic [3:0]    req_level;
  logic [3:0]    cpu_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  prio_vector_ctrl #(.NUM_TRAPS(NT), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_flag(irq_flag),
    .irq_en(irq_en), .irq_prio(irq_prio), .alt_sel(alt_sel),
    .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .int_req(int_req),
    .vec_num(vec_num), .vec_addr(vec_addr), .req_level(req_level),
    .cpu_level(cpu_level)
  );

  typedef struct packed {
    logic [3:0]  trap;
    logic [11:0] flag;
    logic [11:0] en;
    logic [2:0]  base_p;
    logic [3:0]  hi_src;
    logic [2:0]  hi_p;
    logic        alt;
    logic        exp_req;
    logic [6:0]  exp_vec;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t TBL [NROWS] = '{
    '{4'h0, 12'h000, 12'h000, 3'd0, 4'd0,  3'd0, 1'b0, 1'b0, 7'd0},   // R3 idle
    '{4'h0, 12'h008, 12'h008, 3'd1, 4'd0,  3'd1, 1'b0, 1'b1, 7'd7},   // R4 single
    '{4'h0, 12'h0F0, 12'hFFF, 3'd2, 4'd0,  3'd2, 1'b0, 1'b1, 7'd8},   // R4 tie
    '{4'h0, 12'h0F0, 12'hFFF, 3'd2, 4'd6,  3'd5, 1'b0, 1'b1, 7'd10},  // R4 level
    '{4'h0, 12'h001, 12'h000, 3'd7, 4'd0,  3'd7, 1'b0, 1'b0, 7'd0},   // R3 disabled
    '{4'h0, 12'hFFF, 12'hFFF, 3'd0, 4'd11, 3'd1, 1'b0, 1'b1, 7'd15},  // R3 level 0
    '{4'hA, 12'hFFF, 12'h000, 3'd7, 4'd0,  3'd7, 1'b0, 1'b1, 7'd1},   // R2 trap
    '{4'h0, 12'h0F0, 12'hFFF, 3'd2, 4'd6,  3'd5, 1'b1, 1'b1, 7'd10},  // R5 alt
    '{4'h8, 12'h000, 12'h000, 3'd0, 4'd0,  3'd0, 1'b1, 1'b1, 7'd3},   // R5 alt trap
    '{4'h0, 12'hC00, 12'hC00, 3'd3, 4'd11, 3'd3, 1'b0, 1'b1, 7'd14}   // R4 tie high
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_addr(input int vec, input logic alt);
    return (alt ? (4 + TOT * 2) : 4) + vec * 2;
  endfunction

  task automatic set_src(input int s, input int p);
    irq_flag[s] = 1'b1;
    irq_en[s] = 1'b1;
    irq_prio[s*3 +: 3] = 3'(p);
  endtask

  task automatic clear_all();
    trap_req = '0; irq_flag = '0; irq_en = '0; irq_prio = '0; alt_sel = 1'b0;
  endtask

  task automatic ack_once();
    cpu_ack = 1'b1;
    tick(1);
    cpu_ack = 1'b0;
  endtask

  task automatic ret_once();
    cpu_ret = 1'b1;
    tick(1);
    cpu_ret = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run ended)");
    summary();
    $finish;
  end

  initial begin
    // R1: outputs held at zero under reset even with requests pending
    trap_req = 4'h1;
    set_src(0, 5);
    tick(3);
    check("R1 int_req in reset", int'(int_req), 0);
    check("R1 vec_addr in reset", int'(vec_addr), 0);
    check("R1 cpu_level in reset", int'(cpu_level), 0);
    clear_all();
    tick(1);
    rst_n = 1'b1;
    tick(1);
    check("R1 int_req after reset", int'(int_req), 0);
    check("R1 vec_num after reset", int'(vec_num), 0);
    check("R1 req_level after reset", int'(req_level), 0);

    // table walk at running level 0
    for (int r = 0; r < NROWS; r++) begin
      int lvl;
      trap_req = TBL[r].trap;
      irq_flag = TBL[r].flag;
      irq_en   = TBL[r].en;
      alt_sel  = TBL[r].alt;
      for (int s = 0; s < NI; s++)
        irq_prio[s*3 +: 3] = (s == int'(TBL[r].hi_src)) ? TBL[r].hi_p : TBL[r].base_p;
      tick(2);
      check($sformatf("R4 row %0d int_req", r), int'(int_req), int'(TBL[r].exp_req));
      if (TBL[r].exp_req) begin
        if (int'(TBL[r].exp_vec) < NT) lvl = 8;
        else if (int'(TBL[r].exp_vec) - NT == int'(TBL[r].hi_src)) lvl = int'(TBL[r].hi_p);
        else lvl = int'(TBL[r].base_p);
        check($sformatf("R4 row %0d vec_num", r), int'(vec_num), int'(TBL[r].exp_vec));
        check($sformatf("R5 row %0d vec_addr", r), int'(vec_addr),
              exp_addr(int'(TBL[r].exp_vec), TBL[r].alt));
        check($sformatf("R2 row %0d req_level", r), int'(req_level), lvl);
      end else begin
        check($sformatf("R6 row %0d idle vec_addr", r), int'(vec_addr), 0);
      end
    end
    clear_all();
    tick(3);

    // R6: two-edge latency
    set_src(2, 3);
    tick(1);
    check("R6 after one edge", int'(int_req), 0);
    tick(1);
    check("R6 after two edges", int'(int_req), 1);
    check("R6 vec_num", int'(vec_num), 6);

    // R7: acceptance raises the level and withdraws the request
    ack_once();
    check("R7 cpu_level after ack", int'(cpu_level), 3);
    check("R7 int_req after ack", int'(int_req), 0);
    tick(1);
    check("R7 int_req second cycle", int'(int_req), 0);
    tick(2);
    check("R3 same level blocked", int'(int_req), 0);

    set_src(5, 6);
    tick(2);
    check("R3 higher level passes", int'(int_req), 1);
    check("R4 nested vec_num", int'(vec_num), 9);
    ack_once();
    check("R7 cpu_level nested", int'(cpu_level), 6);

    trap_req = 4'h1;
    tick(2);
    check("R2 trap over level 6", int'(vec_num), 0);
    check("R2 trap level", int'(req_level), 8);
    check("R5 trap addr", int'(vec_addr), 4);
    ack_once();
    check("R7 cpu_level trap", int'(cpu_level), 8);
    tick(2);
    check("R2 trap blocked at level 8", int'(int_req), 0);
    trap_req = '0;

    // R8: unwinding
    ret_once();
    check("R8 restore 6", int'(cpu_level), 6);
    ret_once();
    check("R8 restore 3", int'(cpu_level), 3);
    ret_once();
    check("R8 restore 0", int'(cpu_level), 0);
    ret_once();
    check("R8 empty return ignored", int'(cpu_level), 0);
    clear_all();
    tick(3);

    // R9: acknowledge with no request
    check("R9 idle before ack", int'(int_req), 0);
    ack_once();
    check("R9 stray ack", int'(cpu_level), 0);
    ret_once();
    check("R9 nothing saved", int'(cpu_level), 0);

    // R8: return coinciding with an accepted acknowledge
    set_src(1, 2);
    tick(2);
    check("R8 pending before ack+ret", int'(int_req), 1);
    cpu_ack = 1'b1;
    cpu_ret = 1'b1;
    tick(1);
    cpu_ack = 1'b0;
    cpu_ret = 1'b0;
    check("R8 ack wins over ret", int'(cpu_level), 2);
    clear_all();
    ret_once();
    check("R8 final restore", int'(cpu_level), 0);

    summary();
    $finish;
  end
endmodule